// File: doc/BRIEF.md
# GPIO Pad Output Routing Matrix

This block decides, for each of 40 pads, what drives the pad. The source can be any one of 256 peripheral output signals, or a software data bit held in the block. Each pad has its own configuration: a 9-bit source selector, a choice of where the enable comes from, separate inversion of data and enable, and a choice between push-pull and open-drain driving. The result is a data bit and an enable bit per pad. The pad cells themselves are outside this block.

The software data bits and software enable bits live in two register banks inside the block. Each bank is split into a low word, which covers pads 0 to 31, and a high word, which covers pads 32 to 39. Software never writes a whole word. It changes bits through set-mask and clear-mask ports, so a write touches only the bits it names. The routing path is purely combinational, so a peripheral signal reaches its pad in the same cycle. Register contents appear at the pads one clock edge after a mask is applied.

Top module: `gpio_out_matrix`

## Requirements
- R1: After reset, every software data bit and every software enable bit is 0. A pad with selector 256, no inversion and push-pull mode then shows data 0 and enable 0.
- R2: A selector value n below 256 places peripheral output n on the pad data in the same cycle.
- R3: A selector value n below 256 with the enable-source bit at 0 places peripheral enable n on the pad enable.
- R4: A selector value of 256 or more puts the software data bit of that pad on the pad data. Values 257 to 511 behave exactly like 256.
- R5: When the selector is 256 or more, or the enable-source bit is 1, the pad enable comes from the software enable bit of that pad.
- R6: The data-invert bit inverts the chosen data, and the enable-invert bit inverts the chosen enable. Both inversions are applied before open-drain handling.
- R7: With the driver-mode bit at 1 (open drain), the pad data is the effective data. The pad enable is the effective enable ANDed with the inverse of the effective data, so the pad is never driven while its data is 1.
- R8: A 1 in a set mask makes the matching register bit 1 after the next rising edge. Bit i of a low-word mask maps to pad i, and bit j of a high-word mask maps to pad 32+j.
- R9: A 1 in a clear mask makes the matching register bit 0 after the next rising edge. When the set mask and the clear mask both name the same bit in one cycle, the clear wins.
- R10: A register bit named by neither mask keeps its value.
- R11: The asynchronous reset is released through a two-stage synchronizer, so masks applied in the first two cycles after release are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_set_lo | input | 32 | Set mask, software data bits of pads 0..31 |
| dat_set_hi | input | 8 | Set mask, software data bits of pads 32..39 |
| dat_clr_lo | input | 32 | Clear mask, software data bits of pads 0..31 |
| dat_clr_hi | input | 8 | Clear mask, software data bits of pads 32..39 |
| ena_set_lo | input | 32 | Set mask, software enable bits of pads 0..31 |
| ena_set_hi | input | 8 | Set mask, software enable bits of pads 32..39 |
| ena_clr_lo | input | 32 | Clear mask, software enable bits of pads 0..31 |
| ena_clr_hi | input | 8 | Clear mask, software enable bits of pads 32..39 |
| cfg_sel | input | 360 | Source selector of each pad, 9 bits per pad; pad p uses bits [9p+8:9p] |
| cfg_out_inv | input | 40 | Data invert, one bit per pad |
| cfg_oe_sw | input | 40 | 1: enable comes from the software enable bit |
| cfg_oe_inv | input | 40 | Enable invert, one bit per pad |
| cfg_od | input | 40 | 0: push-pull, 1: open drain |
| per_out | input | 256 | Peripheral output signals |
| per_oe | input | 256 | Peripheral enable signals |
| pad_dat | output | 40 | Data to each pad |
| pad_ena | output | 40 | Output enable to each pad |

## Verification
Configuration and peripheral inputs reach the pads with no clock edge between them. The bench therefore drives these inputs just after a falling edge and compares every pad a moment later, within the same cycle. Set and clear masks are registered values, so their effect is due one rising edge later. The bench updates its model on that edge and compares right after it. Reset release takes two further edges before writes are accepted, and the bench leaves the masks at zero through that window, so model and design start from the same state.

// File: rtl/gpio_mtx_pkg.sv
package gpio_mtx_pkg;
  localparam int unsigned PAD_SEL_W = 9;

  typedef struct packed {
    logic [PAD_SEL_W-1:0] sel;
    logic                 out_inv;
    logic                 oe_sw;
    logic                 oe_inv;
    logic                 od;
  } pad_cfg_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_w1_bank.sv
module gpio_w1_bank #(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         upd;

  always_comb begin
    upd   = |(set_m | clr_m);
    q_nxt = (q | set_m) & ~clr_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/gpio_pad_route.sv
module gpio_pad_route
  import gpio_mtx_pkg::*;
#(
  parameter int unsigned N_SIGS = 256
) (
  input  pad_cfg_t          cfg,
  input  logic [N_SIGS-1:0] per_out,
  input  logic [N_SIGS-1:0] per_oe,
  input  logic              sw_d,
  input  logic              sw_e,
  output logic              pad_d,
  output logic              pad_e
);
  localparam int unsigned IDX_W = (N_SIGS > 1) ? $clog2(N_SIGS) : 1;

  logic             use_sw;
  logic [IDX_W-1:0] idx;
  logic             raw_d, raw_e, eff_d, eff_e;

  always_comb begin
    use_sw = (cfg.sel >= PAD_SEL_W'(N_SIGS));
    idx    = cfg.sel[IDX_W-1:0];
    raw_d  = use_sw ? sw_d : per_out[idx];
    raw_e  = (use_sw || cfg.oe_sw) ? sw_e : per_oe[idx];
    eff_d  = raw_d ^ cfg.out_inv;
    eff_e  = raw_e ^ cfg.oe_inv;
    pad_d  = eff_d;
    pad_e  = cfg.od ? (eff_e & ~eff_d) : eff_e;
  end
endmodule

// File: rtl/gpio_out_matrix.sv
module gpio_out_matrix
  import gpio_mtx_pkg::*;
#(
  parameter int unsigned N_PADS = 40,
  parameter int unsigned N_SIGS = 256,
  parameter int unsigned LO_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LO_W-1:0]               dat_set_lo,
  input  logic [N_PADS-LO_W-1:0]        dat_set_hi,
  input  logic [LO_W-1:0]               dat_clr_lo,
  input  logic [N_PADS-LO_W-1:0]        dat_clr_hi,
  input  logic [LO_W-1:0]               ena_set_lo,
  input  logic [N_PADS-LO_W-1:0]        ena_set_hi,
  input  logic [LO_W-1:0]               ena_clr_lo,
  input  logic [N_PADS-LO_W-1:0]        ena_clr_hi,
  input  logic [N_PADS*PAD_SEL_W-1:0]   cfg_sel,
  input  logic [N_PADS-1:0]             cfg_out_inv,
  input  logic [N_PADS-1:0]             cfg_oe_sw,
  input  logic [N_PADS-1:0]             cfg_oe_inv,
  input  logic [N_PADS-1:0]             cfg_od,
  input  logic [N_SIGS-1:0]             per_out,
  input  logic [N_SIGS-1:0]             per_oe,
  output logic [N_PADS-1:0]             pad_dat,
  output logic [N_PADS-1:0]             pad_ena
);
  logic              rst_sync_n;
  logic [N_PADS-1:0] dset, dclr, eset, eclr;
  logic [N_PADS-1:0] sw_dout, sw_den;

  assign dset = {dat_set_hi, dat_set_lo};
  assign dclr = {dat_clr_hi, dat_clr_lo};
  assign eset = {ena_set_hi, ena_set_lo};
  assign eclr = {ena_clr_hi, ena_clr_lo};

  gpio_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_w1_bank #(.W(N_PADS)) u_dbank (
    .clk(clk), .rst_n(rst_sync_n), .set_m(dset), .clr_m(dclr), .q(sw_dout)
  );

  gpio_w1_bank #(.W(N_PADS)) u_ebank (
    .clk(clk), .rst_n(rst_sync_n), .set_m(eset), .clr_m(eclr), .q(sw_den)
  );

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    pad_cfg_t pcfg;
    assign pcfg.sel     = cfg_sel[p*PAD_SEL_W +: PAD_SEL_W];
    assign pcfg.out_inv = cfg_out_inv[p];
    assign pcfg.oe_sw   = cfg_oe_sw[p];
    assign pcfg.oe_inv  = cfg_oe_inv[p];
    assign pcfg.od      = cfg_od[p];

    gpio_pad_route #(.N_SIGS(N_SIGS)) u_route (
      .cfg(pcfg), .per_out(per_out), .per_oe(per_oe),
      .sw_d(sw_dout[p]), .sw_e(sw_den[p]),
      .pad_d(pad_dat[p]), .pad_e(pad_ena[p])
    );
  end
endmodule

// File: rtl/gpio_out_matrix_chk.sv
module gpio_out_matrix_chk
  import gpio_mtx_pkg::*;
#(
  parameter int unsigned N_PADS = 40,
  parameter int unsigned N_SIGS = 256
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic [N_PADS-1:0]           dset,
  input logic [N_PADS-1:0]           dclr,
  input logic [N_PADS-1:0]           eset,
  input logic [N_PADS-1:0]           eclr,
  input logic [N_PADS-1:0]           sw_dout,
  input logic [N_PADS-1:0]           sw_den,
  input logic [N_PADS*PAD_SEL_W-1:0] cfg_sel,
  input logic [N_PADS-1:0]           cfg_out_inv,
  input logic [N_PADS-1:0]           cfg_od,
  input logic [N_SIGS-1:0]           per_out,
  input logic [N_PADS-1:0]           pad_dat,
  input logic [N_PADS-1:0]           pad_ena
);
  localparam int unsigned IDX_W = (N_SIGS > 1) ? $clog2(N_SIGS) : 1;

  for (genvar p = 0; p < N_PADS; p++) begin : g_chk
    logic [PAD_SEL_W-1:0] s;
    logic                 is_per;
    assign s      = cfg_sel[p*PAD_SEL_W +: PAD_SEL_W];
    assign is_per = (s < PAD_SEL_W'(N_SIGS));

    // R2: peripheral data reaches the pad unchanged without inversion
    a_r2_periph_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (is_per && !cfg_out_inv[p]) |-> (pad_dat[p] == per_out[s[IDX_W-1:0]]));

    // R4: software data bit reaches the pad for selectors at or above the limit
    a_r4_sw_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!is_per && !cfg_out_inv[p]) |-> (pad_dat[p] == sw_dout[p]));

    // R7: open drain never drives a high level
    a_r7_od_no_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_od[p] && pad_dat[p]) |-> !pad_ena[p]);

    // R8: set mask alone makes the bit 1
    a_r8_set_dat: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (dset[p] && !dclr[p]) |=> sw_dout[p]);
    a_r8_set_ena: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (eset[p] && !eclr[p]) |=> sw_den[p]);

    // R9: clear mask wins
    a_r9_clr_dat: assert property (@(posedge clk) disable iff (!rst_sync_n)
      dclr[p] |=> !sw_dout[p]);
    a_r9_clr_ena: assert property (@(posedge clk) disable iff (!rst_sync_n)
      eclr[p] |=> !sw_den[p]);

    // R10: untouched bits hold
    a_r10_hold_dat: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!dset[p] && !dclr[p]) |=> $stable(sw_dout[p]));
    a_r10_hold_ena: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!eset[p] && !eclr[p]) |=> $stable(sw_den[p]));
  end
endmodule

bind gpio_out_matrix gpio_out_matrix_chk #(.N_PADS(N_PADS), .N_SIGS(N_SIGS)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .dset(dset), .dclr(dclr), .eset(eset), .eclr(eclr),
  .sw_dout(sw_dout), .sw_den(sw_den),
  .cfg_sel(cfg_sel), .cfg_out_inv(cfg_out_inv), .cfg_od(cfg_od),
  .per_out(per_out), .pad_dat(pad_dat), .pad_ena(pad_ena)
);

// File: tb/tb_gpio_out_matrix.sv
module tb_gpio_out_matrix;
  localparam int CLK_P = 10;
  localparam int NP = 40;
  localparam int NS = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] dsl, dcl, esl, ecl;
  logic [7:0]  dsh, dch, esh, ech;
  logic [NP*9-1:0] sel;
  logic [NP-1:0] oinv, oesw, oeinv, od;
  logic [NS-1:0] pout, poe;
  logic [NP-1:0] pad_dat, pad_ena;

  bit rd[NP];
  bit re[NP];
  int nchk = 0;
  int nfail = 0;
  bit model_live = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_out_matrix dut (
    .clk(clk), .rst_n(rst_n),
    .dat_set_lo(dsl), .dat_set_hi(dsh), .dat_clr_lo(dcl), .dat_clr_hi(dch),
    .ena_set_lo(esl), .ena_set_hi(esh), .ena_clr_lo(ecl), .ena_clr_hi(ech),
    .cfg_sel(sel), .cfg_out_inv(oinv), .cfg_oe_sw(oesw), .cfg_oe_inv(oeinv),
    .cfg_od(od), .per_out(pout), .per_oe(poe),
    .pad_dat(pad_dat), .pad_ena(pad_ena)
  );

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic check(string tag);
    bit bad = 0;
    nchk++;
    for (int p = 0; p < NP; p++) begin
      int  s = int'(sel[p*9 +: 9]);
      bit  rawd, rawe, ed, ee;
      if (s < NS) begin
        rawd = pout[s];
        rawe = oesw[p] ? re[p] : poe[s];
      end else begin
        rawd = rd[p];
        rawe = re[p];
      end
      ed = rawd ^ oinv[p];
      ee = rawe ^ oeinv[p];
      if (od[p]) ee = ee & !ed;
      if (pad_dat[p] !== ed || pad_ena[p] !== ee) begin
        $display("FAIL %s pad %0d: actual dat=%b ena=%b expected dat=%b ena=%b",
                 tag, p, pad_dat[p], pad_ena[p], ed, ee);
        bad = 1;
      end
    end
    if (bad) nfail++;
  endtask

  task automatic clear_masks();
    dsl = '0; dcl = '0; esl = '0; ecl = '0;
    dsh = '0; dch = '0; esh = '0; ech = '0;
  endtask

  // one clock: model updates on the rising edge, compare just after it
  task automatic tick(string tag);
    @(posedge clk);
    if (model_live) begin
      for (int p = 0; p < NP; p++) begin
        bit ds = (p < 32) ? dsl[p] : dsh[p-32];
        bit dc = (p < 32) ? dcl[p] : dch[p-32];
        bit es = (p < 32) ? esl[p] : esh[p-32];
        bit ec = (p < 32) ? ecl[p] : ech[p-32];
        if (dc) rd[p] = 0; else if (ds) rd[p] = 1;
        if (ec) re[p] = 0; else if (es) re[p] = 1;
      end
    end
    #1;
    check(tag);
    @(negedge clk);
  endtask

  task automatic all_sel(int v);
    for (int p = 0; p < NP; p++) sel[p*9 +: 9] = 9'(v);
  endtask

  initial begin
    #(CLK_P * 150000);
    $display("FAIL watchdog expired");
    nchk++; nfail++;
    report();
    $finish;
  end

  initial begin
    rst_n = 0;
    clear_masks();
    all_sel(256);
    oinv = '0; oesw = '0; oeinv = '0; od = '0;
    pout = '0; poe = '0;
    // R1: reset values with software source everywhere
    repeat (3) @(negedge clk);
    #1 check("R1 reset");
    rst_n = 1;
    // R11: masks during synchronizer window are ignored
    dsl = '1; esl = '1; dsh = '1; esh = '1;
    @(posedge clk); #1 check("R11 sync window");
    @(negedge clk);
    clear_masks();
    tick("R11 sync window");
    model_live = 1;
    tick("R1 after release");

    // R8: set data and enable bits, low and high words
    dsl = 32'hA5A5_0F0F; dsh = 8'h3C;
    tick("R8 set data");
    clear_masks();
    esl = 32'h0FF0_3C3C; esh = 8'hC3;
    tick("R8 R5 set enable");
    clear_masks();
    // R10: hold with no masks
    tick("R10 hold");
    tick("R10 hold");
    // R9: clear wins over set on the same bits
    dsl = 32'hFFFF_0000; dcl = 32'h00FF_00FF; dsh = 8'hF0; dch = 8'h30;
    esl = 32'h1111_1111; ecl = 32'h1010_1010; esh = 8'h01; ech = 8'h81;
    tick("R9 clear wins");
    clear_masks();
    tick("R10 hold after clear");

    // R4: selector values above 256 behave like 256
    for (int p = 0; p < NP; p++) sel[p*9 +: 9] = 9'(257 + p * 6);
    #1 check("R4 high selectors");
    @(negedge clk);
    all_sel(511);
    #1 check("R4 selector 511");
    @(negedge clk);

    // R2 R3: peripheral routing under several patterns
    for (int p = 0; p < NP; p++) sel[p*9 +: 9] = 9'((p * 7 + 3) % 256);
    sel[0 +: 9] = 9'd0; sel[39*9 +: 9] = 9'd255;
    pout = {8{32'hDEAD_BEEF}}; poe = {8{32'h1234_5678}};
    #1 check("R2 R3 pattern a");
    @(negedge clk);
    pout = ~pout; poe = ~poe;
    #1 check("R2 R3 pattern b");
    @(negedge clk);
    pout = '1; poe = '0;
    #1 check("R2 R3 pattern c");
    @(negedge clk);
    // R5: software enable source while routing peripheral data
    oesw = 40'hAA_AAAA_AAAA;
    #1 check("R5 enable source");
    @(negedge clk);
    // R6: inversion of data and enable
    oinv = 40'hF0_F0F0_F0F0; oeinv = 40'h33_3333_3333;
    #1 check("R6 inversion");
    @(negedge clk);
    // R7: open drain with mixed data
    od = 40'hFF_FFFF_FFFF; pout = {8{32'h6969_9696}}; poe = '1;
    #1 check("R7 open drain");
    @(negedge clk);
    all_sel(256); oinv = '0; oeinv = '0; oesw = '0;
    #1 check("R7 open drain software source");
    @(negedge clk);
    od = '0;

    // mixed random traffic, compared every clock
    for (int c = 0; c < 200; c++) begin
      for (int p = 0; p < NP; p++) sel[p*9 +: 9] = 9'($urandom_range(0, 511));
      for (int k = 0; k < NS / 32; k++) begin
        pout[k*32 +: 32] = $urandom();
        poe[k*32 +: 32]  = $urandom();
      end
      oinv = {$urandom(), $urandom()} ; oesw = {$urandom(), $urandom()};
      oeinv = {$urandom(), $urandom()}; od = {$urandom(), $urandom()};
      dsl = $urandom(); dcl = $urandom() & $urandom();
      esl = $urandom(); ecl = $urandom() & $urandom();
      dsh = 8'($urandom()); dch = 8'($urandom());
      esh = 8'($urandom()); ech = 8'($urandom());
      #1 check("R2 R3 R4 R5 R6 R7 random comb");
      tick("R8 R9 R10 random regs");
    end
    clear_masks();
    tick("R10 final hold");

    report();
    $finish;
  end
endmodule